// File: doc/BRIEF.md
# Saturating Wiper Position Counter with Tap Decode

This block holds the position of one digitally adjustable resistor wiper as a 6-bit value and turns it into a one-hot select for 64 tap switches along the resistor string. The position can be changed in four ways: a value captured once after reset from a stored default, a direct write of a host byte, a parallel copy from a data register, and single steps up or down while a step mode is open.

In step mode each rising edge of a step clock input moves the wiper one segment. The level of a direction input at that edge picks the way: high moves toward the high terminal, low toward the low terminal. A step counts only when the step mode is open and the pot select input matches this instance's identity. The count stops at either end tap instead of wrapping. The tap select is registered, so it changes on the same clock edge as the position. Only one tap line is ever active.

Top module: `wiper_counter`

## Requirements
- R1: While reset is asserted, `wiper_pos` is 0 and `tap_sel` has only bit 0 set.
- R2: On the first enabled cycle after reset is released, `wiper_pos` takes the value of `boot_val`. The internal reset release takes two clock edges, so the value is seen within four cycles.
- R3: A cycle with `host_wr` high sets `wiper_pos` to `host_val` at the next clock edge.
- R4: A cycle with `xfr_ld` high and `host_wr` low sets `wiper_pos` to `xfr_val` at the next clock edge.
- R5: When `host_wr` and `xfr_ld` are both high in one cycle, the host value wins.
- R6: A load (`host_wr` or `xfr_ld`) in the same cycle as a qualified step takes priority, and the step is dropped.
- R7: A qualified step happens on a 0-to-1 transition of `step_clk`. It adds 1 when `step_dir` is 1 and subtracts 1 when `step_dir` is 0. Holding `step_clk` high gives only one step.
- R8: An up step at 63 (0x3F) leaves 63, and a down step at 0 leaves 0.
- R9: A rising `step_clk` has no effect when `step_mode` is 0 or `pot_sel` differs from the `POT_ID` parameter.
- R10: `tap_sel` is one-hot with bit `wiper_pos` set. Position 0 selects the low-terminal tap (bit 0) and position 63 selects the high-terminal tap (bit 63). It updates on the same edge as `wiper_pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| boot_val | input | 6 | Stored default loaded once after reset |
| host_wr | input | 1 | Host direct-write strobe |
| host_val | input | 6 | Host write value |
| xfr_ld | input | 1 | Parallel load strobe from a data register |
| xfr_val | input | 6 | Parallel load value |
| step_mode | input | 1 | Step mode open for the current transaction |
| pot_sel | input | 2 | Pot select for step mode |
| step_clk | input | 1 | Step pulse level, a rising edge requests a step |
| step_dir | input | 1 | Step direction, 1 toward high terminal |
| wiper_pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | One-hot tap switch select |

## Verification
The bench pushes the wiper against both end taps. A wrapping counter would jump from 63 to 0 or from 0 to 63 there. It holds `step_clk` high for several cycles, which catches a level-sensitive step that keeps counting. It issues steps with the mode closed or the wrong pot selected, which catches a qualifier that ignores either input. It fires loads and steps in the same cycle, and host and parallel loads together, so that a wrong priority order shows as the wrong value. A long random run then compares both outputs each cycle against a bench model. That run catches a tap select that lags the position by a cycle or is not one-hot.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Which update source drives the position in a given cycle
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_BOOT = 3'd1,
    SRC_HOST = 3'd2,
    SRC_XFR  = 3'd3,
    SRC_STEP = 3'd4
  } upd_src_e;

  // A qualified step request
  typedef struct packed {
    logic fire;
    logic up;
  } step_req_t;

endpackage

// File: rtl/wiper_rst_sync.sv
module wiper_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/wiper_step_qual.sv
module wiper_step_qual
  import wiper_pkg::*;
#(
  parameter int SEL_W  = 2,
  parameter int POT_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_clk,
  input  logic             step_dir,
  input  logic             step_mode,
  input  logic [SEL_W-1:0] pot_sel,
  output step_req_t        req
);

  localparam logic [SEL_W-1:0] MY_ID = SEL_W'(POT_ID);

  logic prev_q;
  logic prev_d;
  logic rise;
  logic match;

  // Previous level resets high so a level already high at release is no edge
  always_comb begin
    prev_d = step_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rise     = step_clk & ~prev_q;
    match    = (pot_sel == MY_ID);
    req.fire = rise & step_mode & match;
    req.up   = step_dir;
  end

  // R7: a held step level cannot fire on two consecutive cycles
  p_single_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req.fire |=> !req.fire);

endmodule

// File: rtl/wiper_next.sv
module wiper_next
  import wiper_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             boot,
  input  logic             host_wr,
  input  logic [POS_W-1:0] host_val,
  input  logic             xfr_ld,
  input  logic [POS_W-1:0] xfr_val,
  input  step_req_t        req,
  input  logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_d,
  output logic             upd_en
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  upd_src_e         src;
  logic [POS_W-1:0] stepped;

  // Priority: boot default, host write, parallel load, step
  always_comb begin
    if (boot)          src = SRC_BOOT;
    else if (host_wr)  src = SRC_HOST;
    else if (xfr_ld)   src = SRC_XFR;
    else if (req.fire) src = SRC_STEP;
    else               src = SRC_HOLD;
  end

  // Saturating single step
  always_comb begin
    stepped = pos_q;
    if (req.up) begin
      if (pos_q != POS_MAX) stepped = pos_q + POS_W'(1);
    end else begin
      if (pos_q != POS_MIN) stepped = pos_q - POS_W'(1);
    end
  end

  always_comb begin
    unique case (src)
      SRC_BOOT: pos_d = pos_q;
      SRC_HOST: pos_d = host_val;
      SRC_XFR:  pos_d = xfr_val;
      SRC_STEP: pos_d = stepped;
      default:  pos_d = pos_q;
    endcase
    upd_en = (src != SRC_HOLD);
  end

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int POS_W = 6,
  parameter int TAPS  = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [POS_W-1:0] pos_d,
  output logic [TAPS-1:0]  tap_q
);

  logic [TAPS-1:0] tap_d;

  genvar gi;
  generate
    for (gi = 0; gi < TAPS; gi++) begin : g_tap
      assign tap_d[gi] = (pos_d == POS_W'(gi));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= TAPS'(1);
    end else if (en) begin
      tap_q <= tap_d;
    end
  end

  // R10: exactly one switch closed at all times
  p_tap_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tap_q));

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
  import wiper_pkg::*;
#(
  parameter int POS_W  = 6,
  parameter int SEL_W  = 2,
  parameter int POT_ID = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [POS_W-1:0]       boot_val,
  input  logic                   host_wr,
  input  logic [POS_W-1:0]       host_val,
  input  logic                   xfr_ld,
  input  logic [POS_W-1:0]       xfr_val,
  input  logic                   step_mode,
  input  logic [SEL_W-1:0]       pot_sel,
  input  logic                   step_clk,
  input  logic                   step_dir,
  output logic [POS_W-1:0]       wiper_pos,
  output logic [(1<<POS_W)-1:0]  tap_sel
);

  localparam int               TAPS    = 1 << POS_W;
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic             rst_i;
  logic             boot_q;
  logic             boot_d;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] pos_sel;
  logic             upd_en;
  step_req_t        req;
  logic             any_ld;

  wiper_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  wiper_step_qual #(
    .SEL_W  (SEL_W),
    .POT_ID (POT_ID)
  ) u_step_qual (
    .clk       (clk),
    .rst_n     (rst_i),
    .step_clk  (step_clk),
    .step_dir  (step_dir),
    .step_mode (step_mode),
    .pot_sel   (pot_sel),
    .req       (req)
  );

  wiper_next #(
    .POS_W (POS_W)
  ) u_next (
    .boot     (boot_q),
    .host_wr  (host_wr),
    .host_val (host_val),
    .xfr_ld   (xfr_ld),
    .xfr_val  (xfr_val),
    .req      (req),
    .pos_q    (pos_q),
    .pos_d    (pos_d),
    .upd_en   (upd_en)
  );

  // Boot default enters through the same register path as the other sources
  always_comb begin
    pos_sel = boot_q ? boot_val : pos_d;
    boot_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      boot_q <= 1'b1;
    end else if (boot_q) begin
      boot_q <= boot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pos_q <= '0;
    end else if (upd_en) begin
      pos_q <= pos_sel;
    end
  end

  wiper_tap_decode #(
    .POS_W (POS_W),
    .TAPS  (TAPS)
  ) u_tap (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (upd_en),
    .pos_d (pos_sel),
    .tap_q (tap_sel)
  );

  assign wiper_pos = pos_q;
  assign any_ld    = host_wr | xfr_ld;

  p_boot_load_r2: assert property (@(posedge clk) disable iff (!rst_i)
    boot_q |=> (pos_q == $past(boot_val)));

  p_host_write_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (host_wr && !boot_q) |=> (pos_q == $past(host_val)));

  p_xfr_load_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (xfr_ld && !host_wr && !boot_q) |=> (pos_q == $past(xfr_val)));

  p_host_over_xfr_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (xfr_ld && host_wr && !boot_q) |=> (pos_q == $past(host_val)));

  p_load_over_step_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (req.fire && xfr_ld && !host_wr && !boot_q) |=> (pos_q == $past(xfr_val)));

  p_step_up_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (req.fire && req.up && !any_ld && !boot_q && pos_q != POS_MAX)
      |=> (pos_q == $past(pos_q) + POS_W'(1)));

  p_step_down_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (req.fire && !req.up && !any_ld && !boot_q && pos_q != '0)
      |=> (pos_q == $past(pos_q) - POS_W'(1)));

  p_sat_high_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (req.fire && req.up && !any_ld && !boot_q && pos_q == POS_MAX)
      |=> (pos_q == POS_MAX));

  p_sat_low_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (req.fire && !req.up && !any_ld && !boot_q && pos_q == '0)
      |=> (pos_q == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (!req.fire && !any_ld && !boot_q) |=> $stable(pos_q));

  p_tap_match_r10: assert property (@(posedge clk) disable iff (!rst_i)
    tap_sel[pos_q]);

endmodule

// File: tb/wiper_counter_bench.sv
module wiper_counter_bench;

  localparam int W    = 6;
  localparam int SW   = 2;
  localparam int ID   = 2;
  localparam int TAPS = 1 << W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  boot_val;
  logic          host_wr;
  logic [W-1:0]  host_val;
  logic          xfr_ld;
  logic [W-1:0]  xfr_val;
  logic          step_mode;
  logic [SW-1:0] pot_sel;
  logic          step_clk;
  logic          step_dir;
  logic [W-1:0]  wiper_pos;
  logic [TAPS-1:0] tap_sel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [W-1:0] m_pos;
  logic         m_prev;

  always #5 clk = ~clk;

  wiper_counter #(
    .POS_W  (W),
    .SEL_W  (SW),
    .POT_ID (ID)
  ) u_wiper_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_val  (boot_val),
    .host_wr   (host_wr),
    .host_val  (host_val),
    .xfr_ld    (xfr_ld),
    .xfr_val   (xfr_val),
    .step_mode (step_mode),
    .pot_sel   (pot_sel),
    .step_clk  (step_clk),
    .step_dir  (step_dir),
    .wiper_pos (wiper_pos),
    .tap_sel   (tap_sel)
  );

  // Expected next position from the requirements
  function automatic logic [W-1:0] model_next(
    input logic [W-1:0] p, input logic hw, input logic [W-1:0] hv,
    input logic xl, input logic [W-1:0] xv, input logic md,
    input logic [SW-1:0] ps, input logic sc, input logic sd, input logic prev);
    logic fire;
    fire = sc && !prev && md && (ps == SW'(ID));
    if (hw) return hv;
    if (xl) return xv;
    if (fire) begin
      if (sd) return (p == 6'h3F) ? p : p + 6'd1;
      else    return (p == 6'h00) ? p : p - 6'd1;
    end
    return p;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    logic [TAPS-1:0] exp_tap;
    exp_tap = TAPS'(1) << exp;
    n_chk++;
    if (wiper_pos !== exp || tap_sel !== exp_tap) begin
      n_fail++;
      $display("FAIL %s: pos=%0h tap=%h expected pos=%0h tap=%h",
               tag, wiper_pos, tap_sel, exp, exp_tap);
    end
  endtask

  task automatic idle_inputs();
    host_wr = 1'b0; host_val = '0; xfr_ld = 1'b0; xfr_val = '0;
    step_mode = 1'b0; pot_sel = '0; step_clk = 1'b0; step_dir = 1'b0;
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic apply(input logic hw, input logic [W-1:0] hv,
                       input logic xl, input logic [W-1:0] xv,
                       input logic md, input logic [SW-1:0] ps,
                       input logic sc, input logic sd, input string tag);
    host_wr = hw; host_val = hv; xfr_ld = xl; xfr_val = xv;
    step_mode = md; pot_sel = ps; step_clk = sc; step_dir = sd;
    m_pos  = model_next(m_pos, hw, hv, xl, xv, md, ps, sc, sd, m_prev);
    m_prev = sc;
    @(negedge clk);
    check(tag, m_pos);
  endtask

  task automatic do_reset(input logic [W-1:0] bv);
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 6'h00);
    boot_val = bv;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 boot default", bv);
    m_pos  = bv;
    m_prev = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] other;
    void'($urandom(32'h5EED_0042));
    other = SW'(ID + 1);
    @(negedge clk);
    do_reset(6'h2A);

    apply(1, 6'h3E, 0, 0, 0, 0, 0, 0, "R3 host write");
    apply(0, 0, 0, 0, 1, SW'(ID), 1, 1, "R7 step up");
    apply(0, 0, 0, 0, 1, SW'(ID), 1, 1, "R7 held level no second step");
    apply(0, 0, 0, 0, 1, SW'(ID), 1, 1, "R7 held level no third step");
    apply(0, 0, 0, 0, 1, SW'(ID), 0, 1, "R7 falling edge");
    apply(0, 0, 0, 0, 1, SW'(ID), 1, 1, "R8 saturate at 63 and R10 top tap");
    apply(0, 0, 0, 0, 1, SW'(ID), 0, 1, "R8 idle");
    apply(0, 0, 0, 0, 1, SW'(ID), 1, 1, "R8 saturate at 63 again");
    apply(1, 6'h01, 0, 0, 0, 0, 0, 0, "R3 host write low");
    apply(0, 0, 0, 0, 1, SW'(ID), 1, 0, "R7 step down");
    apply(0, 0, 0, 0, 1, SW'(ID), 0, 0, "R7 idle");
    apply(0, 0, 0, 0, 1, SW'(ID), 1, 0, "R8 saturate at 0 and R10 bottom tap");
    apply(0, 0, 0, 0, 1, SW'(ID), 0, 0, "R8 idle");
    apply(1, 6'h20, 0, 0, 0, 0, 0, 0, "R3 host write mid");
    apply(0, 0, 0, 0, 0, SW'(ID), 1, 1, "R9 mode closed ignores step");
    apply(0, 0, 0, 0, 0, SW'(ID), 0, 1, "R9 idle");
    apply(0, 0, 0, 0, 1, other, 1, 1, "R9 wrong pot ignores step");
    apply(0, 0, 0, 0, 1, other, 0, 1, "R9 idle");
    apply(0, 0, 1, 6'h15, 0, 0, 0, 0, "R4 parallel load");
    apply(1, 6'h0C, 1, 6'h33, 0, 0, 0, 0, "R5 host over parallel");
    apply(0, 0, 1, 6'h07, 1, SW'(ID), 1, 1, "R6 load beats step");
    apply(0, 0, 0, 0, 1, SW'(ID), 0, 1, "R6 idle");
    apply(1, 6'h2B, 0, 0, 1, SW'(ID), 1, 0, "R6 host beats step");

    @(negedge clk);
    do_reset(6'h3F);

    for (int i = 0; i < 3000; i++) begin
      logic hw, xl, md, sc, sd;
      logic [W-1:0] hv, xv;
      logic [SW-1:0] ps;
      hw = ($urandom_range(0, 15) == 0);
      xl = ($urandom_range(0, 15) == 0);
      hv = W'($urandom);
      xv = W'($urandom);
      md = ($urandom_range(0, 7) != 0);
      ps = ($urandom_range(0, 3) != 0) ? SW'(ID) : SW'($urandom);
      sc = $urandom_range(0, 1) == 1;
      sd = ($urandom_range(0, 9) < ((i / 300) % 2 == 0 ? 7 : 3));
      apply(hw, hv, xl, xv, md, ps, sc, sd, "R7 R8 R10 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule